// File: doc/BRIEF.md
# Three-Stage Non-Allocating Load Pipe

This block is a load path that reads one 64-bit word per command and never allocates cache lines. A load command brings an address. The word for that address is pushed into the first of three stages. The word that falls out of the last stage is written to the destination register named by the same command. The pipe moves only when a command is accepted. Between commands the three stages hold their contents, however long the gap.

For each accepted command, the block looks the address up in a small data cache. On a hit, the cached word enters the pipe and the command completes at once, with no memory traffic. On a miss, the block reads the word from memory and never writes the cache.

A miss read takes one of two latencies. The block remembers the last DRAM page it read (address bits above bit 11). A read to that same page, while the page is still held open, is short. Any other read is long. The page is treated as closed after a set number of idle cycles. While a read is in flight the block raises a busy signal and ignores commands.

Top module: `bypass_load_pipe`

## Requirements
- R1: After reset, `wr_en`, `cmd_busy` and `mem_req` are low and all three stages hold zero, so the first three commands after reset write the value zero.
- R2: The pipe advances only on an accepted command (`cmd_valid` high while `cmd_busy` is low). A command presented while `cmd_busy` is high is ignored: it produces no write and does not shift the pipe. While no command is accepted, `wr_en` stays low.
- R3: Each accepted command writes back, one cycle after it completes, the word of the command accepted three commands earlier. The write carries `wr_en`=1 and `wr_dst` equal to the command's own destination.
- R4: A command with `clu_hit`=1 completes on its accepting clock edge. `clu_data` enters stage one, `cmd_busy` never rises and `mem_req` stays low.
- R5: A command with `clu_hit`=0 starts a memory read at the next cycle. `mem_req` is high and `mem_addr` holds the command address, stable until completion. The `mem_rdata` value present in the last busy cycle enters stage one.
- R6: A miss read whose page matches the open page, while that page is still held open, keeps `cmd_busy` high for exactly HIT_LAT (2) cycles.
- R7: Page identity is address bits [31:12]. A miss read to a different page, or the first miss read after reset, keeps `cmd_busy` high for exactly MISS_LAT (10) cycles.
- R8: Let g be the number of clock edges from the edge that completed the last memory read to the edge accepting a new miss. The page stays open if g ≤ IDLE_LIMIT (16). If g > IDLE_LIMIT the page is closed and the read takes MISS_LAT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Load command present |
| cmd_addr | input | 32 | Byte address of the 64-bit word to load |
| cmd_dst | input | 5 | Destination register index for the leaving word |
| cmd_busy | output | 1 | Memory read in flight; commands ignored |
| clu_req | output | 1 | Cache lookup strobe (command would be accepted) |
| clu_addr | output | 32 | Cache lookup address |
| clu_hit | input | 1 | Cache lookup hit, same cycle |
| clu_data | input | 64 | Cached word on a hit |
| mem_req | output | 1 | Memory read active |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 64 | Memory read data, taken in the last busy cycle |
| wr_en | output | 1 | Destination register write strobe |
| wr_dst | output | 5 | Destination register index |
| wr_data | output | 64 | Word leaving stage three |

## Verification
A corrupted stage does not appear at the ports right away. It surfaces as a wrong `wr_data` exactly three accepted commands later, so the bench compares every write against its own three-deep model. A wrong open-page record or idle count shows up immediately as a busy window of the wrong length on the next miss. The bench therefore places misses right at the idle limit, one cycle past it, and across a page boundary. A wrongly accepted command during a read shows up as an extra write and a shifted result sequence on every following command.

// File: rtl/blp_pkg.sv
// Shared types for the bypass load pipe.
package blp_pkg;

    // State of the memory read sequencer.
    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_WAIT = 1'b1
    } rd_state_t;

endpackage

// File: rtl/blp_page_tracker.sv
// Open-page tracker: records the page of the last completed memory read and
// reports whether a query address falls in that page while it is still open.
// Assumes rd_done pulses on the final cycle of a read, with rd_addr valid.
module blp_page_tracker #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_LSB   = 12,
    parameter int IDLE_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_busy,
    input  logic              rd_done,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] query_addr,
    output logic              same_open
);
    localparam int PW = ADDR_W - PAGE_LSB;
    localparam int IW = $clog2(IDLE_LIMIT + 1);

    logic [PW-1:0] open_page;
    logic          page_valid;
    logic [IW-1:0] idle_cnt;

    // Record the page touched by each completed read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_page  <= '0;
            page_valid <= 1'b0;
        end else if (rd_done) begin
            open_page  <= rd_addr[ADDR_W-1:PAGE_LSB];
            page_valid <= 1'b1;
        end
    end

    // Count idle edges since the last read completed, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (rd_done) begin
            idle_cnt <= '0;
        end else if (!rd_busy && (idle_cnt != IW'(IDLE_LIMIT))) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // Page is usable if recorded, not timed out, and the query matches.
    always_comb begin
        same_open = page_valid
                 && (idle_cnt < IW'(IDLE_LIMIT))
                 && (query_addr[ADDR_W-1:PAGE_LSB] == open_page);
    end

endmodule

// File: rtl/blp_mem_seq.sv
// Memory read sequencer: holds one read for a fixed latency chosen at start.
// Assumes memory presents valid data on the last cycle of the window.
module blp_mem_seq
    import blp_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int HIT_LAT  = 2,
    parameter int MISS_LAT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              fast,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int CW = $clog2(MISS_LAT + 1);

    rd_state_t   state;
    logic [CW-1:0] cnt;

    // Load the latency at start and count the window down to completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RD_IDLE;
            cnt     <= '0;
            rd_addr <= '0;
        end else begin
            case (state)
                RD_IDLE: begin
                    if (start) begin
                        state   <= RD_WAIT;
                        rd_addr <= start_addr;
                        cnt     <= fast ? CW'(HIT_LAT - 1) : CW'(MISS_LAT - 1);
                    end
                end
                RD_WAIT: begin
                    if (cnt == '0) begin
                        state <= RD_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    // Busy covers the whole window; done marks its final cycle.
    always_comb begin
        busy = (state == RD_WAIT);
        done = busy && (cnt == '0);
    end

endmodule

// File: rtl/blp_stage_chain.sv
// Stage chain: STAGES word registers that shift by one only on 'shift'.
// The tail output is the word leaving the last stage on that shift.
module blp_stage_chain #(
    parameter int DATA_W = 64,
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] tail
);
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [DATA_W-1:0] q;
        logic [DATA_W-1:0] nxt;

        // Select the source of this stage: input word or previous stage.
        if (i == 0) begin : g_head
            always_comb nxt = din;
        end else begin : g_body
            always_comb nxt = g_stage[i-1].q;
        end

        // Hold unless a command shifts the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (shift) begin
                q <= nxt;
            end
        end
    end

    // Word leaving the last stage.
    always_comb tail = g_stage[STAGES-1].q;

endmodule

// File: rtl/bypass_load_pipe.sv
// Three-stage non-allocating load pipe. Each accepted command pushes one word
// (cached on hit, memory on miss) into the chain and writes the word leaving
// the chain to the command's destination. Commands are ignored while busy.
// Assumes the cache answers the lookup in the same cycle.
module bypass_load_pipe #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int DST_W      = 5,
    parameter int STAGES     = 3,
    parameter int PAGE_LSB   = 12,
    parameter int HIT_LAT    = 2,
    parameter int MISS_LAT   = 10,
    parameter int IDLE_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DST_W-1:0]  cmd_dst,
    output logic              cmd_busy,
    output logic              clu_req,
    output logic [ADDR_W-1:0] clu_addr,
    input  logic              clu_hit,
    input  logic [DATA_W-1:0] clu_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wr_en,
    output logic [DST_W-1:0]  wr_dst,
    output logic [DATA_W-1:0] wr_data
);
    logic              accept;
    logic              hit_acc;
    logic              miss_acc;
    logic              rd_busy;
    logic              rd_done;
    logic              fast;
    logic              shift;
    logic [DATA_W-1:0] din;
    logic [DATA_W-1:0] tail;
    logic [DST_W-1:0]  dst_hold;

    // Accept decode and cache lookup drive.
    always_comb begin
        accept   = cmd_valid && !rd_busy;
        hit_acc  = accept && clu_hit;
        miss_acc = accept && !clu_hit;
        clu_req  = accept;
        clu_addr = cmd_addr;
        cmd_busy = rd_busy;
        mem_req  = rd_busy;
        shift    = hit_acc || rd_done;
        din      = hit_acc ? clu_data : mem_rdata;
    end

    blp_page_tracker #(
        .ADDR_W     (ADDR_W),
        .PAGE_LSB   (PAGE_LSB),
        .IDLE_LIMIT (IDLE_LIMIT)
    ) u_page (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_busy    (rd_busy),
        .rd_done    (rd_done),
        .rd_addr    (mem_addr),
        .query_addr (cmd_addr),
        .same_open  (fast)
    );

    blp_mem_seq #(
        .ADDR_W   (ADDR_W),
        .HIT_LAT  (HIT_LAT),
        .MISS_LAT (MISS_LAT)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (miss_acc),
        .fast       (fast),
        .start_addr (cmd_addr),
        .busy       (rd_busy),
        .done       (rd_done),
        .rd_addr    (mem_addr)
    );

    blp_stage_chain #(
        .DATA_W (DATA_W),
        .STAGES (STAGES)
    ) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (shift),
        .din   (din),
        .tail  (tail)
    );

    // Keep the destination of a miss until its read completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_hold <= '0;
        end else if (miss_acc) begin
            dst_hold <= cmd_dst;
        end
    end

    // Register the write-back of the word leaving the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_dst  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= shift;
            if (shift) begin
                wr_dst  <= hit_acc ? cmd_dst : dst_hold;
                wr_data <= tail;
            end
        end
    end

endmodule

// File: rtl/blp_checker.sv
// Protocol checker for the bypass load pipe, attached by bind below.
module blp_checker #(
    parameter int ADDR_W   = 32,
    parameter int HIT_LAT  = 2,
    parameter int MISS_LAT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_busy,
    input logic              clu_hit,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              wr_en
);
    localparam int CW = $clog2(MISS_LAT + 2);

    logic [CW-1:0] blen;

    // Measure the length of each busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blen <= '0;
        end else if (cmd_busy) begin
            blen <= blen + 1'b1;
        end else begin
            blen <= '0;
        end
    end

    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && $past(cmd_busy)) |-> $stable(mem_addr));

    p_miss_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_busy && !clu_hit) |=> (cmd_busy && mem_req));

    p_hit_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_busy && clu_hit) |=> (wr_en && !cmd_busy && !mem_req));

    p_window_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_busy) |-> ((blen == CW'(HIT_LAT)) || (blen == CW'(MISS_LAT))));

    p_write_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(cmd_valid && !cmd_busy && clu_hit) || $fell(cmd_busy)));

endmodule

bind bypass_load_pipe blp_checker #(
    .ADDR_W   (ADDR_W),
    .HIT_LAT  (HIT_LAT),
    .MISS_LAT (MISS_LAT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_busy  (cmd_busy),
    .clu_hit   (clu_hit),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .wr_en     (wr_en)
);

// File: tb/sim_bypass_load_pipe.sv
`timescale 1ns/1ps
module sim_bypass_load_pipe;
    localparam int HIT_LAT    = 2;
    localparam int MISS_LAT   = 10;
    localparam int IDLE_LIMIT = 16;
    localparam int NV         = 13;

    // Vector: addr[46:15] hit[14] dst[13:9] idle_wait[8:1] poke[0]
    localparam logic [46:0] VEC [NV] = '{
        {32'h0000_1000, 1'b0, 5'd1,  8'd0,  1'b0},
        {32'h0000_1008, 1'b0, 5'd2,  8'd0,  1'b0},
        {32'h0000_2000, 1'b1, 5'd3,  8'd0,  1'b0},
        {32'h0000_1010, 1'b0, 5'd4,  8'd0,  1'b0},
        {32'h0000_3000, 1'b0, 5'd5,  8'd0,  1'b1},
        {32'h0000_3008, 1'b0, 5'd6,  8'd15, 1'b0},
        {32'h0000_3010, 1'b0, 5'd7,  8'd16, 1'b0},
        {32'h0000_4000, 1'b1, 5'd8,  8'd5,  1'b0},
        {32'h0000_4008, 1'b1, 5'd9,  8'd0,  1'b0},
        {32'h0000_3018, 1'b0, 5'd10, 8'd0,  1'b0},
        {32'h1234_5FF8, 1'b0, 5'd11, 8'd0,  1'b0},
        {32'h1234_6000, 1'b0, 5'd12, 8'd0,  1'b0},
        {32'h1234_6FF8, 1'b0, 5'd13, 8'd0,  1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [4:0]  cmd_dst = '0;
    logic        cmd_busy;
    logic        clu_req;
    logic [31:0] clu_addr;
    logic        clu_hit = 1'b0;
    logic [63:0] clu_data = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [63:0] mem_rdata;
    logic        wr_en;
    logic [4:0]  wr_dst;
    logic [63:0] wr_data;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int nwr = 0;
    int ncmd = 0;
    int since_rst = 0;
    bit finished = 0;

    logic [63:0] mdl [3];
    int          last_done = 0;
    logic [19:0] opage = '0;
    bit          ovalid = 0;

    always #2 clk = ~clk;

    bypass_load_pipe u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_dst(cmd_dst), .cmd_busy(cmd_busy), .clu_req(clu_req),
        .clu_addr(clu_addr), .clu_hit(clu_hit), .clu_data(clu_data),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .wr_en(wr_en), .wr_dst(wr_dst), .wr_data(wr_data)
    );

    function automatic logic [63:0] cachef(input logic [31:0] a);
        return {~a, a};
    endfunction

    function automatic logic [63:0] memf(input logic [31:0] a);
        return {a, a ^ 32'h0F0F_0F0F};
    endfunction

    always_comb mem_rdata = memf(mem_addr);

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) if (wr_en) nwr <= nwr + 1;

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 3; i++) mdl[i] = '0;
        ovalid = 0;
        since_rst = 0;
    endtask

    task automatic issue(input logic [31:0] a, input bit h, input logic [4:0] d,
                         input int w, input bit poke);
        int acc;
        int n;
        int explat;
        logic [63:0] expw;
        for (int k = 0; k < w; k++) begin
            @(negedge clk);
            chk(wr_en, 0, "R2 no write without command");
        end
        cmd_valid = 1'b1; cmd_addr = a; clu_hit = h; clu_data = cachef(a); cmd_dst = d;
        @(posedge clk);
        @(negedge clk);
        acc = cyc;
        cmd_valid = 1'b0;
        if (h) explat = 0;
        else if (ovalid && (acc - last_done) <= IDLE_LIMIT && opage == a[31:12]) explat = HIT_LAT;
        else explat = MISS_LAT;
        if (h) chk(mem_req, 0, "R4 no memory read on hit");
        else chk({mem_req, mem_addr}, {1'b1, a}, "R5 read request address");
        n = 0;
        while (cmd_busy) begin
            if (poke && n == 0) begin
                cmd_valid = 1'b1; clu_hit = 1'b1; cmd_dst = 5'd31; cmd_addr = a + 64;
            end
            if (n == 1) cmd_valid = 1'b0;
            if (n > 0) chk(mem_addr, a, "R5 address held");
            n++;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk(n, explat, (explat == HIT_LAT) ? "R6 open page latency" :
                       (explat == MISS_LAT) ? "R7 closed page latency" : "R4 hit latency");
        expw = mdl[2];
        chk(wr_en, 1, "R3 write strobe");
        chk(wr_dst, d, "R3 write destination");
        chk(wr_data, expw, (since_rst < 3) ? "R1 zero from reset" : "R3 word from three back");
        mdl[2] = mdl[1]; mdl[1] = mdl[0]; mdl[0] = h ? cachef(a) : memf(a);
        if (!h) begin
            last_done = cyc; opage = a[31:12]; ovalid = 1;
        end
        ncmd++;
        since_rst++;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        clear_model();
        repeat (4) @(negedge clk);
        chk({wr_en, cmd_busy, mem_req}, 3'b000, "R1 outputs idle in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk({wr_en, cmd_busy, mem_req}, 3'b000, "R1 outputs idle after reset");
        chk(wr_data, 0, "R1 write data zero");

        // Table walk: R2..R8 via vector fields.
        for (int i = 0; i < NV; i++)
            issue(VEC[i][46:15], VEC[i][14], VEC[i][13:9], int'(VEC[i][8:1]), VEC[i][0]);

        // R8 exact edge: IDLE_LIMIT edges open, one more closed.
        issue(32'h0000_7000, 1'b0, 5'd14, 0, 1'b0);
        issue(32'h0000_7008, 1'b0, 5'd15, IDLE_LIMIT - 1, 1'b0);
        issue(32'h0000_7010, 1'b0, 5'd16, IDLE_LIMIT, 1'b0);
        issue(32'h0000_7018, 1'b0, 5'd17, 40, 1'b0);

        // R1: reset mid-run clears stages and page record.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk({wr_en, cmd_busy, mem_req}, 3'b000, "R1 idle during second reset");
        rst_n = 1'b1;
        clear_model();
        issue(32'h0000_7020, 1'b0, 5'd18, 0, 1'b0);
        issue(32'h0000_8000, 1'b1, 5'd19, 0, 1'b0);
        issue(32'h0000_7028, 1'b0, 5'd20, 0, 1'b0);
        issue(32'h0000_8008, 1'b1, 5'd21, 3, 1'b0);

        @(negedge clk);
        chk(nwr, ncmd, "R2 one write per accepted command");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule